// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver with Byte Parity

This block joins two 16-bit ports, called A and B, with one data path for each direction. Each path has a mode input that picks one of three behaviours. In flow-through mode the output follows the input. In latched mode a latch enable makes the path transparent while it is high and freezes the path while it is low. In clocked mode the path takes a new word on each rising clock edge. Every byte of a word has its own parity bit, and the parity is odd.

On the A-to-B path a global mode input chooses between two roles. In the first role the path produces fresh parity bits for the outgoing word. In the second role it forwards the incoming parity bits and checks them. The B-to-A path always checks. Each direction reports one active-low error flag, which goes low when either byte of the word seen at that path's output fails the parity check. The flags are active-low, so flags from several blocks can be combined with a wired-AND.

Each direction also has an active-low output enable. The enable is passed out as an explicit active-high drive enable, so that the pad ring can build the tri-state buffer.

Top module: `bus_parity_xcvr`

## Requirements
- R1: Path mode encoding: 2'b00 is flow-through, 2'b01 is latched, and 2'b10 or 2'b11 is clocked. In flow-through mode the data and parity outputs equal the inputs in the same cycle.
- R2: In latched mode the output follows the input while the latch enable is 1. While the latch enable is 0, the output holds the word taken at the last rising clock edge at which the latch enable was 1.
- R3: In clocked mode the output changes only at a rising clock edge. It then shows the input word that was present at that edge.
- R4: Parity is odd. Parity bit i covers data bits [8i+7:8i]. A byte is valid when its eight data bits and its parity bit together hold an odd number of ones.
- R5: When gen_mode_i is 1, b_par_o carries freshly generated odd parity for b_data_o. In this role a_par_i is ignored and ab_err_no stays 1.
- R6: When gen_mode_i is 0, b_par_o carries the forwarded A-side parity bits. ab_err_no is 0 exactly when at least one byte of the A-to-B output word is invalid.
- R7: The B-to-A path never generates parity. a_par_o always carries the forwarded B-side parity, and ba_err_no is 0 exactly when at least one byte of the B-to-A output word is invalid, whatever the value of gen_mode_i.
- R8: When a direction's oe_ni input is 1, that direction's drive-enable output is 0 and its data and parity outputs are 0. The other direction is not affected.
- R9: While rst_ni is 0, the held words take the value data 0 with all parity bits 1, which is a valid word. In clocked mode both error flags then read 1.
- R10: The error flags evaluate the word at the path output. In clocked mode an invalid word at the input does not change the flag until the edge that captures that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the clocked and latched capture |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_mode_i | input | 1 | 1: A-to-B generates parity; 0: both directions check |
| ab_mode_i | input | 2 | A-to-B path mode |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| a_data_i | input | 16 | A-side data in |
| a_par_i | input | 2 | A-side parity in, one bit per byte |
| b_data_o | output | 16 | B-side data out |
| b_par_o | output | 2 | B-side parity out |
| b_oe_o | output | 1 | B-side drive enable |
| ab_err_no | output | 1 | A-to-B parity error, active low |
| ba_mode_i | input | 2 | B-to-A path mode |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| b_data_i | input | 16 | B-side data in |
| b_par_i | input | 2 | B-side parity in |
| a_data_o | output | 16 | A-side data out |
| a_par_o | output | 2 | A-side parity out |
| a_oe_o | output | 1 | A-side drive enable |
| ba_err_no | output | 1 | B-to-A parity error, active low |

## Verification
In clocked mode, the capture of a new word and the parity evaluation of the held word take place around the same edge. The bench sets up a valid held word and then presents an invalid word at the input. It checks that the flag stays released before the edge and drops after the edge. In the same way, the bench hands the same invalid words to the A-to-B path in the generating role and to the B-to-A path in the same cycle. It then checks that one flag stays released while the other drops, each against a parity count made by hand.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    PATH_FLOW    = 2'b00,
    PATH_LATCH   = 2'b01,
    PATH_CLOCK   = 2'b10,
    PATH_CLOCK_X = 2'b11
  } path_mode_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 18,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import xcvr_pkg::*;

  logic [W-1:0] held_q;
  logic         capture;

  assign capture = mode_i[1] | ((path_mode_e'(mode_i) == PATH_LATCH) & le_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= RST_VAL;
    else if (capture) held_q <= d_i;
  end

  always_comb begin
    unique case (path_mode_e'(mode_i))
      PATH_FLOW:  q_o = d_i;
      PATH_LATCH: q_o = le_i ? d_i : held_q;
      default:    q_o = held_q;
    endcase
  end
endmodule

// File: rtl/xcvr_parity.sv
module xcvr_parity #(
  parameter int unsigned BYTES  = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = BYTES * BYTE_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [BYTES-1:0]  par_i,
  output logic [BYTES-1:0]  gen_par_o,
  output logic [BYTES-1:0]  bad_o
);
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    // odd parity: generated bit makes the count of ones odd
    assign gen_par_o[g] = ~^data_i[g*BYTE_W +: BYTE_W];
    assign bad_o[g]     = ~^{data_i[g*BYTE_W +: BYTE_W], par_i[g]};
  end
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
  parameter int unsigned BYTES   = 2,
  parameter int unsigned BYTE_W  = 8,
  parameter bit          GEN_CAP = 1'b1,
  localparam int unsigned DATA_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              le_i,
  input  logic              oe_ni,
  input  logic              gen_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BYTES-1:0]  par_i,
  output logic [DATA_W-1:0] data_o,
  output logic [BYTES-1:0]  par_o,
  output logic              oe_o,
  output logic              err_no
);
  localparam int unsigned WORD_W = DATA_W + BYTES;
  localparam logic [WORD_W-1:0] RST_WORD = {{BYTES{1'b1}}, {DATA_W{1'b0}}};

  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] path_data;
  logic [BYTES-1:0]  path_par, gen_par, bad, out_par;
  logic              err_n;

  xcvr_store #(.W(WORD_W), .RST_VAL(RST_WORD)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .le_i   (le_i),
    .d_i    ({par_i, data_i}),
    .q_o    (word_q)
  );

  assign path_data = word_q[DATA_W-1:0];
  assign path_par  = word_q[WORD_W-1:DATA_W];

  xcvr_parity #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_par (
    .data_i    (path_data),
    .par_i     (path_par),
    .gen_par_o (gen_par),
    .bad_o     (bad)
  );

  if (GEN_CAP) begin : g_gen
    assign out_par = gen_i ? gen_par : path_par;
    assign err_n   = gen_i | ~(|bad);
  end else begin : g_chk
    logic unused_gen;
    assign unused_gen = gen_i ^ (^gen_par);
    assign out_par    = path_par;
    assign err_n      = ~(|bad);
  end

  assign oe_o   = ~oe_ni;
  assign data_o = oe_o ? path_data : '0;
  assign par_o  = oe_o ? out_par : '0;
  assign err_no = err_n;
endmodule

// File: rtl/bus_parity_xcvr.sv
module bus_parity_xcvr #(
  parameter int unsigned BYTES  = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_mode_i,
  input  logic [1:0]        ab_mode_i,
  input  logic              ab_le_i,
  input  logic              ab_oe_ni,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [BYTES-1:0]  a_par_i,
  output logic [DATA_W-1:0] b_data_o,
  output logic [BYTES-1:0]  b_par_o,
  output logic              b_oe_o,
  output logic              ab_err_no,
  input  logic [1:0]        ba_mode_i,
  input  logic              ba_le_i,
  input  logic              ba_oe_ni,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic [BYTES-1:0]  b_par_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic [BYTES-1:0]  a_par_o,
  output logic              a_oe_o,
  output logic              ba_err_no
);
  xcvr_dir #(.BYTES(BYTES), .BYTE_W(BYTE_W), .GEN_CAP(1'b1)) u_ab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (ab_mode_i),
    .le_i   (ab_le_i),
    .oe_ni  (ab_oe_ni),
    .gen_i  (gen_mode_i),
    .data_i (a_data_i),
    .par_i  (a_par_i),
    .data_o (b_data_o),
    .par_o  (b_par_o),
    .oe_o   (b_oe_o),
    .err_no (ab_err_no)
  );

  // return path is check-only
  xcvr_dir #(.BYTES(BYTES), .BYTE_W(BYTE_W), .GEN_CAP(1'b0)) u_ba (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (ba_mode_i),
    .le_i   (ba_le_i),
    .oe_ni  (ba_oe_ni),
    .gen_i  (gen_mode_i),
    .data_i (b_data_i),
    .par_i  (b_par_i),
    .data_o (a_data_o),
    .par_o  (a_par_o),
    .oe_o   (a_oe_o),
    .err_no (ba_err_no)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int unsigned BYTES  = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = BYTES * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gen_mode_i,
  input logic [1:0]        ab_mode_i,
  input logic              ab_le_i,
  input logic              ab_oe_ni,
  input logic [DATA_W-1:0] a_data_i,
  input logic [BYTES-1:0]  a_par_i,
  input logic [DATA_W-1:0] b_data_o,
  input logic [BYTES-1:0]  b_par_o,
  input logic              b_oe_o,
  input logic              ab_err_no,
  input logic [1:0]        ba_mode_i,
  input logic              ba_le_i,
  input logic              ba_oe_ni,
  input logic [DATA_W-1:0] b_data_i,
  input logic [BYTES-1:0]  b_par_i,
  input logic [DATA_W-1:0] a_data_o,
  input logic [BYTES-1:0]  a_par_o,
  input logic              a_oe_o,
  input logic              ba_err_no
);
  function automatic logic word_ok(input logic [DATA_W-1:0] d, input logic [BYTES-1:0] p);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < BYTES; i++) ok = ok & (^{d[i*BYTE_W +: BYTE_W], p[i]});
    return ok;
  endfunction

  // R1
  flow_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_oe_ni && ab_mode_i == 2'b00) |-> (b_data_o == a_data_i));

  // R3
  clocked_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(ab_mode_i[1]) && ab_mode_i[1] && !ab_oe_ni)
      |-> (b_data_o == $past(a_data_i) && a_oe_o == !ba_oe_ni));

  // R4
  gen_par_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_mode_i && !ab_oe_ni) |-> word_ok(b_data_o, b_par_o));

  // R5
  gen_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_mode_i |-> ab_err_no);

  // R6
  ab_check_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_mode_i && !ab_oe_ni) |-> (ab_err_no == word_ok(b_data_o, b_par_o)));

  // R7
  ba_check_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ba_oe_ni |-> (ba_err_no == word_ok(a_data_o, a_par_o)));

  // R8
  ab_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_oe_ni |-> (!b_oe_o && b_data_o == '0 && b_par_o == '0));

  // R8
  ba_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_oe_ni |-> (!a_oe_o && a_data_o == '0 && a_par_o == '0));

  logic unused_chk;
  assign unused_chk = ab_le_i ^ ba_le_i ^ (^a_par_i) ^ (^b_data_i) ^ (^b_par_i) ^ (^ba_mode_i);
endmodule

bind bus_parity_xcvr xcvr_chk #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tb_bus_parity_xcvr.sv
`timescale 1ns/1ps
module tb_bus_parity_xcvr;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gen_mode_i = 1'b0;
  logic [1:0]  ab_mode_i = 2'b10, ba_mode_i = 2'b10;
  logic        ab_le_i = 1'b0, ba_le_i = 1'b0;
  logic        ab_oe_ni = 1'b0, ba_oe_ni = 1'b0;
  logic [15:0] a_data_i = 16'hFFFF, b_data_i = 16'hFFFF;
  logic [1:0]  a_par_i = 2'b00, b_par_i = 2'b00;
  logic [15:0] b_data_o, a_data_o;
  logic [1:0]  b_par_o, a_par_o;
  logic        b_oe_o, a_oe_o, ab_err_no, ba_err_no;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bus_parity_xcvr dut (
    .clk_i(clk), .rst_ni(rst_ni), .gen_mode_i(gen_mode_i),
    .ab_mode_i(ab_mode_i), .ab_le_i(ab_le_i), .ab_oe_ni(ab_oe_ni),
    .a_data_i(a_data_i), .a_par_i(a_par_i),
    .b_data_o(b_data_o), .b_par_o(b_par_o), .b_oe_o(b_oe_o), .ab_err_no(ab_err_no),
    .ba_mode_i(ba_mode_i), .ba_le_i(ba_le_i), .ba_oe_ni(ba_oe_ni),
    .b_data_i(b_data_i), .b_par_i(b_par_i),
    .a_data_o(a_data_o), .a_par_o(a_par_o), .a_oe_o(a_oe_o), .ba_err_no(ba_err_no)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {gen, data, par, exp_b_par, exp_ab_err_n, exp_ba_err_n}
  localparam logic [22:0] VEC [7] = '{
    {1'b1, 16'h0000, 2'b00, 2'b11, 1'b1, 1'b0},
    {1'b1, 16'h0103, 2'b00, 2'b01, 1'b1, 1'b0},
    {1'b0, 16'h0103, 2'b01, 2'b01, 1'b1, 1'b1},
    {1'b0, 16'h0103, 2'b11, 2'b11, 1'b0, 1'b0},
    {1'b0, 16'hFFFF, 2'b11, 2'b11, 1'b1, 1'b1},
    {1'b0, 16'hFFFF, 2'b10, 2'b10, 1'b0, 1'b0},
    {1'b1, 16'h80FF, 2'b00, 2'b01, 1'b1, 1'b0}
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9: reset state in clocked mode
    repeat (3) @(negedge clk);
    #1;
    check("R9 b_data", 32'(b_data_o), 32'h0);
    check("R9 b_par", 32'(b_par_o), 32'h3);
    check("R9 ab_err_no", 32'(ab_err_no), 32'h1);
    check("R9 ba_err_no", 32'(ba_err_no), 32'h1);
    check("R9 a_data", 32'(a_data_o), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1, R4, R5, R6, R7: flow-through vector table
    ab_mode_i = 2'b00;
    ba_mode_i = 2'b00;
    foreach (VEC[i]) begin
      @(negedge clk);
      gen_mode_i = VEC[i][22];
      a_data_i   = VEC[i][21:6];
      a_par_i    = VEC[i][5:4];
      b_data_i   = VEC[i][21:6];
      b_par_i    = VEC[i][5:4];
      #1;
      check("R1 b_data", 32'(b_data_o), 32'(VEC[i][21:6]));
      check("R5/R6 b_par", 32'(b_par_o), 32'(VEC[i][3:2]));
      check("R4/R6 ab_err_no", 32'(ab_err_no), 32'(VEC[i][1]));
      check("R1 a_data", 32'(a_data_o), 32'(VEC[i][21:6]));
      check("R7 a_par", 32'(a_par_o), 32'(VEC[i][5:4]));
      check("R7 ba_err_no", 32'(ba_err_no), 32'(VEC[i][0]));
    end

    // R2: latched mode
    gen_mode_i = 1'b0;
    @(negedge clk);
    ab_mode_i = 2'b01;
    ab_le_i   = 1'b1;
    a_data_i  = 16'h1234;
    a_par_i   = 2'b11;
    #1;
    check("R2 transparent", 32'(b_data_o), 32'h1234);
    @(negedge clk);
    ab_le_i  = 1'b0;
    a_data_i = 16'h5678;
    #1;
    check("R2 hold", 32'(b_data_o), 32'h1234);
    @(negedge clk);
    #1;
    check("R2 hold after edge", 32'(b_data_o), 32'h1234);

    // R3: clocked mode
    @(negedge clk);
    ab_mode_i = 2'b10;
    a_data_i  = 16'hAAAA;
    a_par_i   = 2'b11;
    #1;
    check("R3 before edge", 32'(b_data_o), 32'h1234);
    @(negedge clk);
    #1;
    check("R3 after edge", 32'(b_data_o), 32'hAAAA);

    // R10: flag follows held word, not the input
    @(negedge clk);
    a_data_i = 16'h0103;
    a_par_i  = 2'b11;
    #1;
    check("R10 flag before edge", 32'(ab_err_no), 32'h1);
    @(negedge clk);
    #1;
    check("R10 flag after edge", 32'(ab_err_no), 32'h0);
    check("R10 data after edge", 32'(b_data_o), 32'h0103);

    // R8: output enable per direction
    @(negedge clk);
    ab_oe_ni = 1'b1;
    ba_mode_i = 2'b00;
    b_data_i = 16'h00F0;
    b_par_i  = 2'b11;
    #1;
    check("R8 b_oe_o", 32'(b_oe_o), 32'h0);
    check("R8 b_data zero", 32'(b_data_o), 32'h0);
    check("R8 b_par zero", 32'(b_par_o), 32'h0);
    check("R8 a_oe_o", 32'(a_oe_o), 32'h1);
    check("R8 a_data", 32'(a_data_o), 32'h00F0);
    @(negedge clk);
    ab_oe_ni = 1'b0;
    ba_oe_ni = 1'b1;
    #1;
    check("R8 a side off", 32'({a_oe_o, a_data_o, a_par_o}), 32'h0);
    check("R8 b side on", 32'(b_oe_o), 32'h1);

    // R9: asynchronous reset mid-run
    @(negedge clk);
    ba_oe_ni = 1'b0;
    ba_mode_i = 2'b10;
    rst_ni = 1'b0;
    #1;
    check("R9 mid b_data", 32'(b_data_o), 32'h0);
    check("R9 mid flags", 32'({ab_err_no, ba_err_no}), 32'h3);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule